// File: doc/BRIEF.md
# ALU with Condition Flag Update

This block performs four 32-bit data-processing operations: add, move, compare and bit-test. It also applies each operation's own rule for updating the N, Z, C and V condition flags. Each transaction carries an opcode, a set-flags bit, the destination register index, two operands, the carry from the upstream shifter and the current flag state. The block returns the result, the destination index, a register write strobe, the new flag state and an error bit. The error bit marks opcodes that are not handled and flag-setting writes to register 15.

Both sides of the block are valid/ready streams. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. Its outcome is held in a single output register until a beat is taken there on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. A full stage therefore costs no bubble. A stalled output holds its value and blocks the input side.

Top module: `alu_flag_unit`

## Requirements
- R1: During reset and in the first cycle after reset, `out_valid` is low and `in_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, every output field keeps its value and `in_ready` is low. A new beat may enter in the same cycle that the held one leaves.
- R3: Add (opcode 4h) outputs `op1 + op2` modulo 2^32 and asserts the write strobe. With the set-flags bit high, the flag vector {N,Z,C,V} (bits 3,2,1,0) becomes: N = result bit 31; Z = result is zero; C = unsigned carry out; V = both operands' signs differ from the result's sign.
- R4: Add and move with the set-flags bit low pass the incoming flags through unchanged and still assert the write strobe.
- R5: Compare (opcode Ah) outputs `op1 - op2` and never asserts the write strobe. It sets N and Z from the difference and sets C when `op2 <= op1` (unsigned). It sets V when the operands differ in sign and the difference's sign differs from `op1`.
- R6: Bit-test (opcode 8h) outputs `op1 & op2` and never asserts the write strobe. It always sets N and Z from that value and takes C from the shifter carry, whatever the set-flags bit is. V passes through.
- R7: Move (opcode Dh) outputs `op2` and asserts the write strobe. With the set-flags bit high, it sets N and Z from `op2`, takes C from the shifter carry and passes V through.
- R8: An add or move with the set-flags bit high and destination index 15 raises the error bit. It drops the write strobe and leaves all flags unchanged. Compare and bit-test ignore the destination index.
- R9: Any other opcode raises the error bit. It outputs a zero result, drops the write strobe and leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_opcode | input | 4 | Operation code |
| in_set_flags | input | 1 | Request flag update for add/move |
| in_rd | input | 4 | Destination register index |
| in_op1 | input | 32 | First operand |
| in_op2 | input | 32 | Second operand (shifter output) |
| in_shift_c | input | 1 | Carry out of the shifter |
| in_flags | input | 4 | Current {N,Z,C,V} |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_result | output | 32 | Operation result |
| out_rd | output | 4 | Destination register index |
| out_wr_en | output | 1 | Register write strobe |
| out_flags | output | 4 | Updated {N,Z,C,V} |
| out_error | output | 1 | Unsupported opcode or blocked register-15 flag write |

## Verification
Two events can fall in the same cycle: the held output beat is handed off, and the next input beat is taken. The bench parks one beat behind a low `out_ready`, presents a second beat, and then raises `out_ready` for a single edge. It judges the outcome by checking three things. The first beat stays unchanged through the stall. `in_ready` follows `out_ready` combinationally. The very next output is the second beat with its own flags, with no lost or repeated beat. Flag outcomes are compared against a model written from the requirements, including carry and overflow edges and the register-15 block.

// File: rtl/alu_flag_pkg.sv
`timescale 1ns/1ps
package alu_flag_pkg;
  localparam logic [3:0] OPC_ADD = 4'h4;
  localparam logic [3:0] OPC_TST = 4'h8;
  localparam logic [3:0] OPC_CMP = 4'hA;
  localparam logic [3:0] OPC_MOV = 4'hD;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/alu_arith.sv
`timescale 1ns/1ps
// Raw arithmetic/logic datapath: sum, difference, conjunction and their carry/overflow terms.
module alu_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         sum_c,
  output logic         sum_v,
  output logic [W-1:0] diff,
  output logic         diff_nb,
  output logic         diff_v,
  output logic [W-1:0] conj
);
  localparam int MSB = W - 1;

  logic [W:0] sum_ext;
  logic [W:0] diff_ext;

  assign sum_ext  = {1'b0, a} + {1'b0, b};
  assign diff_ext = {1'b0, a} - {1'b0, b};

  assign sum     = sum_ext[W-1:0];
  assign sum_c   = sum_ext[W];
  assign diff    = diff_ext[W-1:0];
  // top bit of the widened difference is the borrow
  assign diff_nb = ~diff_ext[W];

  assign sum_v  = (a[MSB] ^ sum[MSB]) & (b[MSB] ^ sum[MSB]);
  assign diff_v = (a[MSB] ^ diff[MSB]) & (~b[MSB] ^ diff[MSB]);

  assign conj = a & b;
endmodule

// File: rtl/alu_flag_sel.sv
`timescale 1ns/1ps
// Per-opcode selection of result, write strobe and flag update policy.
module alu_flag_sel
  import alu_flag_pkg::*;
#(
  parameter int W      = 32,
  parameter int RIDX_W = 4,
  parameter int PC_IDX = 15
) (
  input  logic [3:0]        opcode,
  input  logic              set_flags,
  input  logic [RIDX_W-1:0] rd,
  input  logic [W-1:0]      mov_val,
  input  logic [W-1:0]      sum,
  input  logic              sum_c,
  input  logic              sum_v,
  input  logic [W-1:0]      diff,
  input  logic              diff_nb,
  input  logic              diff_v,
  input  logic [W-1:0]      conj,
  input  logic              shift_c,
  input  nzcv_t             flags_in,
  output logic [W-1:0]      result,
  output logic              wr_en,
  output nzcv_t             flags_out,
  output logic              unsup
);
  localparam logic [RIDX_W-1:0] PC_SEL = RIDX_W'(PC_IDX);
  localparam int MSB = W - 1;

  logic pc_guard;
  assign pc_guard = set_flags && (rd == PC_SEL);

  always_comb begin
    result    = '0;
    wr_en     = 1'b0;
    flags_out = flags_in;
    unsup     = 1'b0;
    case (opcode)
      OPC_ADD: begin
        result = sum;
        if (pc_guard) begin
          unsup = 1'b1;
        end else begin
          wr_en = 1'b1;
          if (set_flags) begin
            flags_out.n = sum[MSB];
            flags_out.z = ~|sum;
            flags_out.c = sum_c;
            flags_out.v = sum_v;
          end
        end
      end
      OPC_MOV: begin
        result = mov_val;
        if (pc_guard) begin
          unsup = 1'b1;
        end else begin
          wr_en = 1'b1;
          if (set_flags) begin
            flags_out.n = mov_val[MSB];
            flags_out.z = ~|mov_val;
            flags_out.c = shift_c;
          end
        end
      end
      OPC_CMP: begin
        result      = diff;
        flags_out.n = diff[MSB];
        flags_out.z = ~|diff;
        flags_out.c = diff_nb;
        flags_out.v = diff_v;
      end
      OPC_TST: begin
        result      = conj;
        flags_out.n = conj[MSB];
        flags_out.z = ~|conj;
        flags_out.c = shift_c;
      end
      default: unsup = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_out_reg.sv
`timescale 1ns/1ps
// One-entry output register with valid/ready on both sides; full throughput.
module alu_out_reg #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !out_valid);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/alu_flag_unit.sv
`timescale 1ns/1ps
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int W      = 32,
  parameter int RIDX_W = 4,
  parameter int PC_IDX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_opcode,
  input  logic              in_set_flags,
  input  logic [RIDX_W-1:0] in_rd,
  input  logic [W-1:0]      in_op1,
  input  logic [W-1:0]      in_op2,
  input  logic              in_shift_c,
  input  logic [3:0]        in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_result,
  output logic [RIDX_W-1:0] out_rd,
  output logic              out_wr_en,
  output logic [3:0]        out_flags,
  output logic              out_error
);
  localparam int PW = W + RIDX_W + 1 + 4 + 1;

  logic [W-1:0] sum, diff, conj, sel_result;
  logic         sum_c, sum_v, diff_nb, diff_v;
  logic         sel_wr, sel_unsup;
  nzcv_t        flags_cur, sel_flags;
  logic [PW-1:0] pay_in, pay_out;

  assign flags_cur = nzcv_t'(in_flags);

  alu_arith #(.W(W)) u_arith (
    .a(in_op1), .b(in_op2),
    .sum(sum), .sum_c(sum_c), .sum_v(sum_v),
    .diff(diff), .diff_nb(diff_nb), .diff_v(diff_v),
    .conj(conj)
  );

  alu_flag_sel #(.W(W), .RIDX_W(RIDX_W), .PC_IDX(PC_IDX)) u_sel (
    .opcode(in_opcode), .set_flags(in_set_flags), .rd(in_rd),
    .mov_val(in_op2), .sum(sum), .sum_c(sum_c), .sum_v(sum_v),
    .diff(diff), .diff_nb(diff_nb), .diff_v(diff_v), .conj(conj),
    .shift_c(in_shift_c), .flags_in(flags_cur),
    .result(sel_result), .wr_en(sel_wr), .flags_out(sel_flags), .unsup(sel_unsup)
  );

  assign pay_in = {sel_result, in_rd, sel_wr, sel_flags, sel_unsup};

  alu_out_reg #(.PW(PW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(pay_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pay_out)
  );

  assign {out_result, out_rd, out_wr_en, out_flags, out_error} = pay_out;

  logic accept;
  assign accept = in_valid & in_ready;

  assert_nos_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_set_flags && (in_opcode == OPC_ADD || in_opcode == OPC_MOV))
    |=> (out_flags == $past(in_flags)));

  assert_tst_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_opcode == OPC_TST) |=> (out_flags[1] == $past(in_shift_c) && !out_wr_en));

  assert_mov_vkeep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_opcode == OPC_MOV) |=> (out_flags[0] == $past(in_flags[0])));

  assert_pc_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_set_flags && in_rd == RIDX_W'(PC_IDX) &&
     (in_opcode == OPC_ADD || in_opcode == OPC_MOV))
    |=> (out_error && !out_wr_en && out_flags == $past(in_flags)));

  assert_err_nowr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_error) |-> !out_wr_en);
endmodule

// File: tb/alu_flag_unit_tb.sv
`timescale 1ns/1ps
module alu_flag_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_set_flags = 1'b0, in_shift_c = 1'b0, out_ready = 1'b1;
  logic [3:0] in_opcode = '0, in_rd = '0, in_flags = '0;
  logic [31:0] in_op1 = '0, in_op2 = '0;
  logic in_ready, out_valid, out_wr_en, out_error;
  logic [31:0] out_result;
  logic [3:0] out_rd, out_flags;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  alu_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_set_flags(in_set_flags), .in_rd(in_rd),
    .in_op1(in_op1), .in_op2(in_op2), .in_shift_c(in_shift_c), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_rd(out_rd), .out_wr_en(out_wr_en), .out_flags(out_flags), .out_error(out_error)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model written from the requirements
  function automatic void model(input logic [3:0] opc, input logic s, input logic [3:0] rd,
                                input logic [31:0] a, input logic [31:0] b, input logic sc,
                                input logic [3:0] fl, output logic [31:0] r, output logic we,
                                output logic [3:0] fo, output logic er);
    logic [32:0] t;
    r = '0; we = 1'b0; fo = fl; er = 1'b0;
    case (opc)
      4'h4: begin
        t = {1'b0, a} + {1'b0, b};
        r = t[31:0];
        if (s && rd == 4'd15) er = 1'b1;
        else begin
          we = 1'b1;
          if (s) fo = {r[31], r == 32'd0, t[32], (a[31] == b[31]) && (r[31] != a[31])};
        end
      end
      4'hA: begin
        r = a - b;
        fo = {r[31], r == 32'd0, b <= a, (a[31] != b[31]) && (r[31] != a[31])};
      end
      4'h8: begin
        r = a & b;
        fo = {r[31], r == 32'd0, sc, fl[0]};
      end
      4'hD: begin
        r = b;
        if (s && rd == 4'd15) er = 1'b1;
        else begin
          we = 1'b1;
          if (s) fo = {b[31], b == 32'd0, sc, fl[0]};
        end
      end
      default: er = 1'b1;
    endcase
  endfunction

  task automatic drive(logic [3:0] opc, logic s, logic [3:0] rd, logic [31:0] a,
                       logic [31:0] b, logic sc, logic [3:0] fl);
    in_valid = 1'b1; in_opcode = opc; in_set_flags = s; in_rd = rd;
    in_op1 = a; in_op2 = b; in_shift_c = sc; in_flags = fl;
  endtask

  task automatic run_op(string req, logic [3:0] opc, logic s, logic [3:0] rd,
                        logic [31:0] a, logic [31:0] b, logic sc, logic [3:0] fl);
    logic [31:0] er_r; logic e_we, e_er; logic [3:0] e_fl;
    model(opc, s, rd, a, b, sc, fl, er_r, e_we, e_fl, e_er);
    @(negedge clk);
    drive(opc, s, rd, a, b, sc, fl);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " result"}, 64'(out_result), 64'(er_r));
    check({req, " rd"}, 64'(out_rd), 64'(rd));
    check({req, " wr_en"}, 64'(out_wr_en), 64'(e_we));
    check({req, " flags"}, 64'(out_flags), 64'(e_fl));
    check({req, " error"}, 64'(out_error), 64'(e_er));
  endtask

  task automatic t_reset();
    check("R1 valid in reset", 64'(out_valid), 64'd0);
    check("R1 ready in reset", 64'(in_ready), 64'd1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", 64'(out_valid), 64'd0);
    check("R1 ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_add();
    run_op("R3 add wrap zero", 4'h4, 1'b1, 4'd2, 32'hFFFF_FFFF, 32'd1, 1'b0, 4'h0);
    check("R3 add wrap flags literal", 64'(out_flags), 64'b0110);
    run_op("R3 add signed ovf", 4'h4, 1'b1, 4'd3, 32'h7FFF_FFFF, 32'd1, 1'b0, 4'h0);
    check("R3 add ovf flags literal", 64'(out_flags), 64'b1001);
    run_op("R3 add neg ovf", 4'h4, 1'b1, 4'd4, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'h0);
    run_op("R3 add plain", 4'h4, 1'b1, 4'd5, 32'd100, 32'd23, 1'b1, 4'hF);
  endtask

  task automatic t_nos();
    run_op("R4 add no S", 4'h4, 1'b0, 4'd1, 32'hFFFF_FFFF, 32'd1, 1'b1, 4'b1001);
    run_op("R4 mov no S", 4'hD, 1'b0, 4'd15, 32'd0, 32'd0, 1'b1, 4'b0110);
  endtask

  task automatic t_cmp();
    run_op("R5 cmp equal", 4'hA, 1'b0, 4'd0, 32'd5, 32'd5, 1'b0, 4'h0);
    check("R5 cmp equal literal", 64'(out_flags), 64'b0110);
    run_op("R5 cmp borrow", 4'hA, 1'b1, 4'd7, 32'd1, 32'd2, 1'b1, 4'h0);
    run_op("R5 cmp ovf", 4'hA, 1'b1, 4'd15, 32'h8000_0000, 32'd1, 1'b0, 4'h0);
    check("R5 cmp ovf literal", 64'(out_flags), 64'b0011);
  endtask

  task automatic t_tst();
    run_op("R6 tst S low", 4'h8, 1'b0, 4'd15, 32'hF000_0000, 32'h8000_00FF, 1'b1, 4'b0001);
    run_op("R6 tst zero", 4'h8, 1'b1, 4'd9, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b0, 4'b1010);
  endtask

  task automatic t_mov();
    run_op("R7 mov zero", 4'hD, 1'b1, 4'd6, 32'h1234_5678, 32'd0, 1'b1, 4'b1001);
    run_op("R7 mov neg", 4'hD, 1'b1, 4'd8, 32'd0, 32'h8000_0001, 1'b0, 4'b0111);
  endtask

  task automatic t_pc();
    run_op("R8 add pc S", 4'h4, 1'b1, 4'd15, 32'h7FFF_FFFF, 32'd1, 1'b0, 4'b0110);
    run_op("R8 mov pc S", 4'hD, 1'b1, 4'd15, 32'd0, 32'd0, 1'b1, 4'b1000);
    run_op("R8 cmp pc ignored", 4'hA, 1'b1, 4'd15, 32'd3, 32'd3, 1'b0, 4'b1001);
  endtask

  task automatic t_unsup();
    run_op("R9 opcode 0", 4'h0, 1'b1, 4'd1, 32'd5, 32'd6, 1'b1, 4'b1010);
    run_op("R9 opcode F", 4'hF, 1'b0, 4'd2, 32'hFFFF_FFFF, 32'd1, 1'b0, 4'b0101);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    drive(4'h4, 1'b1, 4'd1, 32'd10, 32'd20, 1'b0, 4'h0);
    @(posedge clk);
    @(negedge clk);
    drive(4'hA, 1'b1, 4'd2, 32'd1, 32'd2, 1'b0, 4'h0);
    check("R2 ready low when stalled", 64'(in_ready), 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 held result", 64'(out_result), 64'd30);
      check("R2 held flags", 64'(out_flags), 64'b0000);
      check("R2 still stalled", 64'(in_ready), 64'd0);
    end
    out_ready = 1'b1;
    #0.1;
    check("R2 ready follows consumer", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 next beat valid", 64'(out_valid), 64'd1);
    check("R2 next beat result", 64'(out_result), 64'hFFFF_FFFF);
    check("R2 next beat flags", 64'(out_flags), 64'b1000);
    @(negedge clk);
    check("R2 drained", 64'(out_valid), 64'd0);
  endtask

  task automatic t_random();
    logic [3:0] opcs [6] = '{4'h4, 4'h8, 4'hA, 4'hD, 4'h0, 4'hF};
    logic [31:0] edges [5] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1};
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = ($urandom % 3 == 0) ? edges[$urandom % 5] : $urandom;
      b = ($urandom % 3 == 0) ? edges[$urandom % 5] : $urandom;
      run_op("R3 R5 R6 R7 random", opcs[$urandom % 6], 1'($urandom), 4'($urandom),
             a, b, 1'($urandom), 4'($urandom));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_add();
    t_nos();
    t_cmp();
    t_tst();
    t_mov();
    t_pc();
    t_unsup();
    t_backpressure();
    t_random();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule